// File: doc/BRIEF.md
# HMAC two-pass sequencer

This block wraps a plain word-streaming hash engine and turns it into a keyed-hash (HMAC) unit. It holds a 256-bit secret key as eight 32-bit words. Word 0 is the most significant. From the key it builds two 512-bit pad blocks. The inner block is the key followed by 256 zero bits, with every byte XORed with 0x36. The outer block is built the same way with 0x5c. Words are sent most significant first.

A keyed operation runs two passes. The first pass sends the inner pad block and then the caller's message words to the engine. The second pass sends the outer pad block and then the 256-bit digest the engine returned for the first pass. Before each pass the block gives the engine a start pulse. After each pass it gives a process pulse together with the pass's total length in bits. When keying is disabled, the message goes straight through in one pass with no pad blocks.

Writes to the key or to the configuration are locked while an operation runs. A refused key write raises an error code that stays held until it is cleared. The final digest is held on an output, and a one-cycle done pulse marks its arrival.

Both streams use valid/ready handshakes. A word moves on a clock edge where valid and ready are both high. While ready is low, the sender holds valid and data steady. In the message phase, `msg_ready_o` equals `eng_ready_i`, so engine back-pressure reaches the message source directly. In every other phase `msg_ready_o` is low. The end-of-message command `proc_i` is honoured only while the message phase is active and no offered word is stalled. The caller holds it until `eng_process_o` answers.

Top module: `hmac_pass_seq`

## Requirements
- R1: In keyed mode, a start accepted in idle is followed by `eng_start_o` in the next cycle. Sixteen words are then sent. Word i for i<8 is key word i XOR 0x36363636, and words 8 to 15 are 0x36363636.
- R2: After the inner pad words, each message word reaches `eng_data_o` unchanged and in order. `msg_ready_o` equals `eng_ready_i` during this phase.
- R3: An accepted `proc_i` ends the first pass. One cycle later `eng_process_o` pulses with `eng_len_o` equal to 32 times the number of message words plus 512. A word transferred in the same cycle as `proc_i` is counted.
- R4: After the first digest returns, `eng_start_o` pulses again. Sixteen outer pad words follow, using 0x5c in place of 0x36. Then come the eight first-digest words, most significant first. Finally `eng_process_o` pulses with `eng_len_o` = 768.
- R5: With keying disabled, the operation is one pass of only the message words, and `eng_len_o` = 32 times the word count.
- R6: A key write in idle replaces key word `key_idx_i`. A key write while busy is discarded. The next cycle it sets `err_code_o` to 3 and gives a one-cycle `err_pulse_o`.
- R7: The mode register resets to keyed mode and is written only in idle. A mode write while busy is discarded and raises no error.
- R8: In the cycle after the final digest is accepted, `done_o` pulses for one cycle and `result_o` shows that digest. `result_o` then holds it until the next completion.
- R9: `err_code_o` resets to 0 and holds its value until `err_clr_i` clears it. A refused key write in the same cycle as `err_clr_i` leaves the code at 3.
- R10: `start_i` has no effect while busy, and `proc_i` has no effect outside the message phase.
- R11: While `eng_valid_o` is high and `eng_ready_i` is low, `eng_valid_o` stays high and `eng_data_o` stays stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_we_i | input | 1 | Mode register write |
| cfg_hmac_en_i | input | 1 | Mode value: 1 keyed, 0 plain hash |
| key_we_i | input | 1 | Key word write |
| key_idx_i | input | 3 | Key word index, 0 most significant |
| key_wdata_i | input | 32 | Key word data |
| start_i | input | 1 | Begin an operation |
| proc_i | input | 1 | Message complete command |
| msg_valid_i | input | 1 | Message word valid |
| msg_ready_o | output | 1 | Message word accepted |
| msg_data_i | input | 32 | Message word |
| eng_start_o | output | 1 | Engine pass start pulse |
| eng_valid_o | output | 1 | Engine word valid |
| eng_ready_i | input | 1 | Engine ready for word |
| eng_data_o | output | 32 | Engine word |
| eng_process_o | output | 1 | Engine pass end pulse |
| eng_len_o | output | 64 | Pass length in bits, valid with process pulse |
| dig_valid_i | input | 1 | Engine digest valid pulse |
| dig_data_i | input | 256 | Engine digest |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final digest ready pulse |
| result_o | output | 256 | Final digest, word 0 in the top bits |
| err_pulse_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 32 | Held error code |
| err_clr_i | input | 1 | Clear error code |

## Verification
Two pairs of events can land in the same clock cycle, and the bench forces both. In the first pair, a refused key write and `err_clr_i` are driven on the same edge during a busy pass. The code must read 3 afterwards, and the key and the digest must be unaffected. In the second pair, the last message word and `proc_i` are offered together, sometimes under engine back-pressure. The reported first-pass length must count that word, and the word must appear in the logged engine stream.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_INNER_KEY, S_MSG, S_WAIT_DIG1,
    S_OUTER_KEY, S_DIG_FEED, S_WAIT_DIG2, S_DONE
  } seq_state_e;

  localparam logic [7:0]  IPAD_BYTE      = 8'h36;
  localparam logic [7:0]  OPAD_BYTE      = 8'h5c;
  localparam logic [31:0] ERR_KEY_LOCKED = 32'h0000_0003;
endpackage

// File: rtl/hmac_key_store.sv
module hmac_key_store
  import hmac_seq_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int KEY_WORDS   = 8,
  parameter int BLOCK_WORDS = 16,
  localparam int IDX_W      = $clog2(KEY_WORDS),
  localparam int BIDX_W     = $clog2(BLOCK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [IDX_W-1:0]  key_idx_i,
  input  logic [WORD_W-1:0] key_wdata_i,
  input  logic              locked_i,
  input  logic [BIDX_W-1:0] pad_idx_i,
  input  logic              use_outer_i,
  output logic [WORD_W-1:0] pad_word_o,
  output logic              key_refused_o
);
  localparam int BYTES = WORD_W / 8;

  logic [WORD_W-1:0] key_q [KEY_WORDS];
  logic [WORD_W-1:0] pad_rep;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[g] <= '0;
      else if (key_we_i && !locked_i && (int'(key_idx_i) == g)) key_q[g] <= key_wdata_i;
    end

    // R6: a key word must not change under a locked write
    p_key_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (key_we_i && locked_i) |=> $stable(key_q[g]));
  end

  assign key_refused_o = key_we_i && locked_i;
  assign pad_rep = {BYTES{use_outer_i ? OPAD_BYTE : IPAD_BYTE}};

  always_comb begin
    if (int'(pad_idx_i) < KEY_WORDS) pad_word_o = key_q[pad_idx_i[IDX_W-1:0]] ^ pad_rep;
    else                             pad_word_o = pad_rep;
  end
endmodule

// File: rtl/hmac_len_track.sv
module hmac_len_track #(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 16,
  parameter int LEN_W       = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             hmac_mode_i,
  output logic [LEN_W-1:0] len_pass1_o
);
  localparam logic [LEN_W-1:0] PAD_BITS = LEN_W'(BLOCK_WORDS * WORD_W);
  localparam logic [LEN_W-1:0] WBITS    = LEN_W'(WORD_W);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + LEN_W'(1);
  end

  assign cnt_now     = cnt_q + LEN_W'(inc_i);
  assign len_pass1_o = cnt_now * WBITS + (hmac_mode_i ? PAD_BITS : '0);
endmodule

// File: rtl/hmac_pass_fsm.sv
module hmac_pass_fsm
  import hmac_seq_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int KEY_WORDS   = 8,
  parameter int BLOCK_WORDS = 16,
  parameter int LEN_W       = 64,
  localparam int DIG_W      = WORD_W * KEY_WORDS,
  localparam int IDX_W      = $clog2(KEY_WORDS),
  localparam int BIDX_W     = $clog2(BLOCK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              proc_i,
  input  logic              hmac_mode_i,
  input  logic              msg_valid_i,
  input  logic [WORD_W-1:0] msg_data_i,
  input  logic              eng_ready_i,
  input  logic              dig_valid_i,
  input  logic [DIG_W-1:0]  dig_data_i,
  input  logic [WORD_W-1:0] pad_word_i,
  input  logic [LEN_W-1:0]  len_pass1_i,
  output seq_state_e        state_o,
  output logic              msg_ready_o,
  output logic              eng_valid_o,
  output logic [WORD_W-1:0] eng_data_o,
  output logic              eng_start_o,
  output logic              eng_process_o,
  output logic [LEN_W-1:0]  eng_len_o,
  output logic [BIDX_W-1:0] pad_idx_o,
  output logic              use_outer_o,
  output logic              cnt_clear_o,
  output logic              cnt_inc_o,
  output logic [DIG_W-1:0]  result_o,
  output logic              done_o
);
  localparam logic [LEN_W-1:0]  LEN_PASS2 = LEN_W'((BLOCK_WORDS + KEY_WORDS) * WORD_W);
  localparam logic [BIDX_W-1:0] LAST_BLK  = BIDX_W'(BLOCK_WORDS - 1);
  localparam logic [BIDX_W-1:0] LAST_DIG  = BIDX_W'(KEY_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [BIDX_W-1:0] idx_q;
  logic              start_q, proc_q, start_d, proc_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [DIG_W-1:0]  dig1_q, result_q;
  logic [WORD_W-1:0] dig1_w [KEY_WORDS];
  logic              xfer, proc_take, stepping;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_dw
    assign dig1_w[g] = dig1_q[(KEY_WORDS-1-g)*WORD_W +: WORD_W];
  end

  always_comb begin
    eng_valid_o = 1'b0;
    eng_data_o  = '0;
    msg_ready_o = 1'b0;
    unique case (state_q)
      S_INNER_KEY, S_OUTER_KEY: begin
        eng_valid_o = 1'b1;
        eng_data_o  = pad_word_i;
      end
      S_MSG: begin
        eng_valid_o = msg_valid_i;
        eng_data_o  = msg_data_i;
        msg_ready_o = eng_ready_i;
      end
      S_DIG_FEED: begin
        eng_valid_o = 1'b1;
        eng_data_o  = dig1_w[idx_q[IDX_W-1:0]];
      end
      default: ;
    endcase
  end

  assign xfer      = eng_valid_o && eng_ready_i;
  assign proc_take = (state_q == S_MSG) && proc_i && !(msg_valid_i && !eng_ready_i);
  assign stepping  = (state_q == S_INNER_KEY) || (state_q == S_OUTER_KEY) || (state_q == S_DIG_FEED);

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    proc_d  = 1'b0;
    len_d   = len_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = hmac_mode_i ? S_INNER_KEY : S_MSG;
        start_d = 1'b1;
      end
      S_INNER_KEY: if (xfer && idx_q == LAST_BLK) state_d = S_MSG;
      S_MSG: if (proc_take) begin
        state_d = hmac_mode_i ? S_WAIT_DIG1 : S_WAIT_DIG2;
        proc_d  = 1'b1;
        len_d   = len_pass1_i;
      end
      S_WAIT_DIG1: if (dig_valid_i) begin
        state_d = S_OUTER_KEY;
        start_d = 1'b1;
      end
      S_OUTER_KEY: if (xfer && idx_q == LAST_BLK) state_d = S_DIG_FEED;
      S_DIG_FEED: if (xfer && idx_q == LAST_DIG) begin
        state_d = S_WAIT_DIG2;
        proc_d  = 1'b1;
        len_d   = LEN_PASS2;
      end
      S_WAIT_DIG2: if (dig_valid_i) state_d = S_DONE;
      S_DONE:      state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      start_q  <= 1'b0;
      proc_q   <= 1'b0;
      len_q    <= '0;
      dig1_q   <= '0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      proc_q  <= proc_d;
      len_q   <= len_d;
      if (state_q != state_d)    idx_q <= '0;
      else if (stepping && xfer) idx_q <= idx_q + BIDX_W'(1);
      if (state_q == S_WAIT_DIG1 && dig_valid_i) dig1_q   <= dig_data_i;
      if (state_q == S_WAIT_DIG2 && dig_valid_i) result_q <= dig_data_i;
    end
  end

  assign state_o       = state_q;
  assign eng_start_o   = start_q;
  assign eng_process_o = proc_q;
  assign eng_len_o     = len_q;
  assign pad_idx_o     = idx_q;
  assign use_outer_o   = (state_q == S_OUTER_KEY);
  assign cnt_clear_o   = (state_q == S_IDLE) && start_i;
  assign cnt_inc_o     = (state_q == S_MSG) && msg_valid_i && eng_ready_i;
  assign result_o      = result_q;
  assign done_o        = (state_q == S_DONE);

  // R11: generated words hold under back-pressure
  p_pad_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_valid_o && !eng_ready_i && state_q != S_MSG) |=> (eng_valid_o && $stable(eng_data_o)));

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4: pass end after the digest feed carries the fixed length
  p_len_pass2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_process_o && $past(state_q) == S_DIG_FEED) |-> (eng_len_o == LEN_PASS2));

  // R10: a pass start only follows idle or the first digest
  p_start_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> ($past(state_q) == S_IDLE || $past(state_q) == S_WAIT_DIG1));
endmodule

// File: rtl/hmac_pass_seq.sv
module hmac_pass_seq
  import hmac_seq_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int KEY_WORDS   = 8,
  parameter int BLOCK_WORDS = 16,
  parameter int LEN_W       = 64,
  localparam int DIG_W      = WORD_W * KEY_WORDS,
  localparam int IDX_W      = $clog2(KEY_WORDS),
  localparam int BIDX_W     = $clog2(BLOCK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_hmac_en_i,
  input  logic              key_we_i,
  input  logic [IDX_W-1:0]  key_idx_i,
  input  logic [WORD_W-1:0] key_wdata_i,
  input  logic              start_i,
  input  logic              proc_i,
  input  logic              msg_valid_i,
  output logic              msg_ready_o,
  input  logic [WORD_W-1:0] msg_data_i,
  output logic              eng_start_o,
  output logic              eng_valid_o,
  input  logic              eng_ready_i,
  output logic [WORD_W-1:0] eng_data_o,
  output logic              eng_process_o,
  output logic [LEN_W-1:0]  eng_len_o,
  input  logic              dig_valid_i,
  input  logic [DIG_W-1:0]  dig_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DIG_W-1:0]  result_o,
  output logic              err_pulse_o,
  output logic [31:0]       err_code_o,
  input  logic              err_clr_i
);
  seq_state_e        state;
  logic              busy, hmac_q, key_refused;
  logic [BIDX_W-1:0] pad_idx;
  logic              use_outer, cnt_clear, cnt_inc;
  logic [WORD_W-1:0] pad_word;
  logic [LEN_W-1:0]  len_pass1;
  logic [31:0]       err_code_q;
  logic              err_pulse_q;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hmac_q <= 1'b1;
    else if (cfg_we_i && !busy) hmac_q <= cfg_hmac_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_code_q  <= '0;
      err_pulse_q <= 1'b0;
    end else begin
      err_pulse_q <= key_refused;
      if (key_refused)    err_code_q <= ERR_KEY_LOCKED;
      else if (err_clr_i) err_code_q <= '0;
    end
  end

  hmac_key_store #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .BLOCK_WORDS(BLOCK_WORDS)) u_keys (
    .clk_i, .rst_ni,
    .key_we_i, .key_idx_i, .key_wdata_i,
    .locked_i(busy), .pad_idx_i(pad_idx), .use_outer_i(use_outer),
    .pad_word_o(pad_word), .key_refused_o(key_refused)
  );

  hmac_len_track #(.WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS), .LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .clear_i(cnt_clear), .inc_i(cnt_inc), .hmac_mode_i(hmac_q),
    .len_pass1_o(len_pass1)
  );

  hmac_pass_fsm #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .BLOCK_WORDS(BLOCK_WORDS),
                  .LEN_W(LEN_W)) u_fsm (
    .clk_i, .rst_ni, .start_i, .proc_i,
    .hmac_mode_i(hmac_q),
    .msg_valid_i, .msg_data_i, .eng_ready_i, .dig_valid_i, .dig_data_i,
    .pad_word_i(pad_word), .len_pass1_i(len_pass1),
    .state_o(state), .msg_ready_o, .eng_valid_o, .eng_data_o,
    .eng_start_o, .eng_process_o, .eng_len_o,
    .pad_idx_o(pad_idx), .use_outer_o(use_outer),
    .cnt_clear_o(cnt_clear), .cnt_inc_o(cnt_inc),
    .result_o, .done_o
  );

  assign busy_o      = busy;
  assign err_code_o  = err_code_q;
  assign err_pulse_o = err_pulse_q;

  // R6: refused key write reports code 3 with a pulse
  p_key_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_refused |=> (err_pulse_o && err_code_o == ERR_KEY_LOCKED));

  // R9: code holds without a clear or a new error
  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_refused && !err_clr_i) |=> $stable(err_code_o));

  // R7: mode cannot change while busy
  p_cfg_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cfg_we_i) |=> $stable(hmac_q));
endmodule

// File: tb/test_hmac_pass_seq.sv
module test_hmac_pass_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0, cfg_hmac_en = 1'b0;
  logic         key_we = 1'b0;
  logic [2:0]   key_idx = '0;
  logic [31:0]  key_wdata = '0;
  logic         start = 1'b0, proc = 1'b0;
  logic         msg_valid = 1'b0;
  logic [31:0]  msg_data = '0;
  logic         msg_ready;
  logic         eng_start, eng_valid, eng_process;
  logic         eng_ready = 1'b1;
  logic [31:0]  eng_data;
  logic [63:0]  eng_len;
  logic         dig_valid = 1'b0;
  logic [255:0] dig_data = '0;
  logic         busy, done, err_pulse;
  logic [255:0] result;
  logic [31:0]  err_code;
  logic         err_clr = 1'b0;

  always #5 clk = ~clk;

  hmac_pass_seq i_hmac_pass_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_hmac_en_i(cfg_hmac_en),
    .key_we_i(key_we), .key_idx_i(key_idx), .key_wdata_i(key_wdata),
    .start_i(start), .proc_i(proc),
    .msg_valid_i(msg_valid), .msg_ready_o(msg_ready), .msg_data_i(msg_data),
    .eng_start_o(eng_start), .eng_valid_o(eng_valid), .eng_ready_i(eng_ready),
    .eng_data_o(eng_data), .eng_process_o(eng_process), .eng_len_o(eng_len),
    .dig_valid_i(dig_valid), .dig_data_i(dig_data),
    .busy_o(busy), .done_o(done), .result_o(result),
    .err_pulse_o(err_pulse), .err_code_o(err_code), .err_clr_i(err_clr)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] step(input logic [255:0] acc, input logic [31:0] w, input int i);
    return {acc[223:0], acc[255:224] ^ w ^ i};
  endfunction

  function automatic logic [31:0] msgw(input logic [15:0] seed, input int i);
    return ({16'h0, seed} * 32'h9E37_79B9) + (i * 32'h0100_0193) ^ i;
  endfunction

  // engine stub
  logic [7:0]   rdy_pat = 8'hFF;
  int           cyc = 0;
  int           pass_n = 0, wc = 0, resp_cnt = 0, stall_bad = 0;
  logic [255:0] acc = '0, resp_val = '0;
  logic         prev_stall = 1'b0;
  logic [31:0]  prev_data = '0;
  logic [31:0]  plog [0:63][0:47];
  logic [63:0]  plen [0:63];
  int           pwc  [0:63];

  always @(posedge clk) begin
    if (!rst_n) begin
      pass_n = 0; wc = 0; resp_cnt = 0; acc = '0; prev_stall = 1'b0;
    end else begin
      if (prev_stall && !(eng_valid && eng_data == prev_data)) stall_bad++;
      prev_stall = eng_valid && !eng_ready;
      prev_data  = eng_data;
      if (resp_cnt > 0) resp_cnt--;
      if (eng_start) begin pass_n++; wc = 0; acc = '0; end
      if (eng_valid && eng_ready) begin
        if (pass_n > 0 && wc < 48) plog[(pass_n-1)%64][wc] = eng_data;
        acc = step(acc, eng_data, wc);
        wc++;
      end
      if (eng_process && pass_n > 0) begin
        plen[(pass_n-1)%64] = eng_len;
        pwc[(pass_n-1)%64]  = wc;
        resp_val = acc ^ {4{eng_len}};
        resp_cnt = 4;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    eng_ready = rdy_pat[cyc%8];
    dig_valid = (resp_cnt == 1);
    dig_data  = resp_val;
  end

  logic [31:0] kmodel [0:7];

  function automatic logic [31:0] padw(input int i, input logic [7:0] b);
    return (i < 8) ? (kmodel[i] ^ {4{b}}) : {4{b}};
  endfunction

  task automatic write_key(input int idx, input logic [31:0] d);
    @(negedge clk);
    key_we = 1'b1; key_idx = 3'(idx); key_wdata = d;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic write_cfg(input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hmac_en = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one full operation with checks
  task automatic run_op(input logic hm, input int n, input logic [15:0] seed,
                        input logic [7:0] pat, input bit pwl, input string tag);
    int base, p1, p2, bad, to;
    bit got;
    logic [255:0] e, d1;
    logic [31:0] w;
    logic [63:0] elen;
    @(negedge clk);
    rdy_pat = pat;
    base = pass_n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      msg_valid = 1'b1; msg_data = msgw(seed, i);
      if (pwl && i == n-1) proc = 1'b1;
      do begin #1; got = msg_ready; @(negedge clk); end while (!got);
    end
    msg_valid = 1'b0;
    proc = 1'b1;
    to = 0;
    while (!eng_process && to < 3000) begin #1; if (!eng_process) @(negedge clk); to++; end
    @(negedge clk);
    proc = 1'b0;
    to = 0;
    while (!done && to < 3000) begin @(negedge clk); to++; end
    chk(done, {tag, " R8 done seen"}, 256'(done), 256'(1));
    @(negedge clk);
    chk(!done, {tag, " R8 done one cycle"}, 256'(done), 256'(0));
    p1 = base % 64; p2 = (base+1) % 64;
    chk(pass_n - base == (hm ? 2 : 1), {tag, " R5 R10 pass count"}, 256'(pass_n - base), 256'(hm ? 2 : 1));
    // pass one
    e = '0; bad = 0;
    for (int i = 0; i < (hm ? 16 : 0) + n; i++) begin
      w = (hm && i < 16) ? padw(i, 8'h36) : msgw(seed, i - (hm ? 16 : 0));
      e = step(e, w, i);
      if (plog[p1][i] !== w) bad++;
    end
    elen = 64'(n*32 + (hm ? 512 : 0));
    chk(bad == 0 && pwc[p1] == (hm ? 16 : 0) + n, {tag, hm ? " R1 R2 pass1 words" : " R5 words"},
        256'(bad), 256'(0));
    chk(plen[p1] == elen, {tag, hm ? " R3 pass1 length" : " R5 length"}, 256'(plen[p1]), 256'(elen));
    e = e ^ {4{elen}};
    if (hm) begin
      d1 = e; e = '0; bad = 0;
      for (int i = 0; i < 24; i++) begin
        w = (i < 16) ? padw(i, 8'h5c) : d1[255-32*(i-16) -: 32];
        e = step(e, w, i);
        if (plog[p2][i] !== w) bad++;
      end
      chk(bad == 0 && pwc[p2] == 24, {tag, " R4 pass2 words"}, 256'(bad), 256'(0));
      chk(plen[p2] == 64'd768, {tag, " R4 pass2 length"}, 256'(plen[p2]), 256'd768);
      e = e ^ {4{64'd768}};
    end
    chk(result == e, {tag, " R8 result"}, result, e);
  endtask

  typedef struct packed {
    logic       hm;
    logic [7:0] n;
    logic [15:0] seed;
    logic [7:0] pat;
    logic       pwl;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 8'd3,  16'h1111, 8'hFF, 1'b0},
    '{1'b1, 8'd0,  16'h2222, 8'hFF, 1'b0},
    '{1'b1, 8'd20, 16'h3333, 8'h6D, 1'b1},
    '{1'b0, 8'd5,  16'h4444, 8'hFF, 1'b0},
    '{1'b0, 8'd0,  16'h5555, 8'hFF, 1'b0},
    '{1'b1, 8'd17, 16'h6666, 8'h33, 1'b1},
    '{1'b0, 8'd9,  16'h7777, 8'hC7, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) kmodel[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !eng_valid && !eng_start && !eng_process, "R10 reset idle outputs",
        256'({busy, done, eng_valid}), 256'(0));
    chk(err_code == 0 && !err_pulse, "R9 reset err_code", 256'(err_code), 256'(0));
    chk(result == '0, "R8 reset result", result, 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // keyed mode by default (R7): run before any config write
    run_op(1'b1, 2, 16'h0ABC, 8'hFF, 1'b0, "default-mode");
    for (int i = 0; i < 8; i++) begin
      kmodel[i] = 32'hA5A5_0000 + 32'(i * 32'h0101_1357);
      write_key(i, kmodel[i]);
    end
    chk(err_code == 0, "R6 idle key write no error", 256'(err_code), 256'(0));

    foreach (VECS[v]) begin
      write_cfg(VECS[v].hm);
      run_op(VECS[v].hm, int'(VECS[v].n), VECS[v].seed, VECS[v].pat, VECS[v].pwl, $sformatf("vec%0d", v));
    end

    // refused key and config writes, start while busy
    write_cfg(1'b1);
    fork
      run_op(1'b1, 4, 16'h0F0F, 8'h11, 1'b0, "locked");
      begin
        repeat (10) @(negedge clk);
        key_we = 1'b1; key_idx = 3'd2; key_wdata = 32'hDEAD_BEEF;
        cfg_we = 1'b1; cfg_hmac_en = 1'b0;
        @(negedge clk);
        key_we = 1'b0; cfg_we = 1'b0;
        chk(err_pulse, "R6 error pulse", 256'(err_pulse), 256'(1));
        chk(err_code == 32'h3, "R6 error code", 256'(err_code), 256'h3);
        @(negedge clk);
        chk(!err_pulse, "R6 error pulse single", 256'(err_pulse), 256'(0));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        proc = 1'b1;
        @(negedge clk);
        proc = 1'b0;
      end
    join
    chk(err_code == 32'h3, "R9 code held", 256'(err_code), 256'h3);
    // mode write was discarded: still keyed (checked inside run_op)
    run_op(1'b1, 1, 16'h1234, 8'hFF, 1'b0, "R7 mode kept");
    chk(err_code == 32'h3, "R7 no error from config", 256'(err_code), 256'h3);

    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_code == 0, "R9 clear", 256'(err_code), 256'(0));

    // clear and refused write in the same cycle
    fork
      run_op(1'b1, 2, 16'h5A5A, 8'h55, 1'b0, "clr-collide");
      begin
        repeat (8) @(negedge clk);
        key_we = 1'b1; key_idx = 3'd0; key_wdata = 32'h0; err_clr = 1'b1;
        @(negedge clk);
        key_we = 1'b0; err_clr = 1'b0;
        chk(err_code == 32'h3, "R9 error beats clear", 256'(err_code), 256'h3);
      end
    join

    chk(stall_bad == 0, "R11 stream stable under stall", 256'(stall_bad), 256'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule